// File: doc/BRIEF.md
# Polar-Rejection Gaussian Noise Source

This block produces a stream of pairs of approximately Gaussian noise samples with the polar rejection method. Eight small free-running shift-register sequence generators supply one bit each. Together they form two 4-bit uniform fractions. A lookup table maps the pair to the squared radius of the matching point in the unit square. A point that lies outside the unit circle, or exactly at its centre, is discarded.

Accepted draws enter a 16-entry buffer. The output side drains the buffer on every second clock, so the sample rate stays constant even though the acceptance rate varies. When the buffer is full the uniform sources freeze, and no draw is lost. On the read side, a second table maps the radius to the scale factor sqrt(-2 ln S / S). Two signed multipliers apply that factor to the centred uniforms to form the two samples.

The block runs on a single clock with an active-low asynchronous reset. It has no data inputs. A user scales and truncates the two outputs to the noise amplitude that the target channel requires.

Top module: `gn_polar_noise`

## Requirements
- R1: While reset is low and at the first edge after reset is released, `valid_o` is 0 and both samples are 0. Every source reloads the all-ones state and the buffer empties, so the sample sequence after each reset is identical.
- R2: Each source is a Fibonacci shift register. Its feedback is the XOR of stage LEN and stage TAP, the new bit enters at stage 1, and its output is stage LEN. The (LEN, TAP) pairs for sources 0 to 7 are (5,3), (6,5), (7,6), (9,5), (10,7), (11,9), (15,14) and (17,14). Bit i of U1 is the output of source i, and bit i of U2 is the output of source 4+i.
- R3: The centred values are V = U - 8, each a 4-bit two's-complement number in units of 1/8. Let D = V1² + V2² in raw units. The radius code is S = 4·D when 0 < D < 64, and 0 otherwise. A draw with S = 0 is rejected and never stored.
- R4: The buffer holds 16 draws. While it holds 16, the sources do not advance and nothing is written. It never overflows and is never read while empty.
- R5: Read slots fall on every second edge, and the first slot is the second edge after reset release. At a slot edge with a non-empty buffer, the oldest draw is removed and `valid_o` is 1 for the following cycle. At every other edge `valid_o` is 0, so `valid_o` is never high in two consecutive cycles.
- R6: The scale code is W = round(256·sqrt(-2·ln(S/256)/(S/256))), saturated to 14 bits. It is unsigned, with 6 integer and 8 fraction bits.
- R7: X1 = V1·W and X2 = V2·W. Each is an 18-bit two's-complement value in units of 2^-11. Both are held unchanged while `valid_o` is 0.
- R8: Samples appear in the order in which their draws were accepted, with none dropped and none repeated.
- R9: An emitted pair never comes from a rejected draw, so a valid pair is never zero in both samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_o | output | 1 | A new sample pair is present this cycle |
| x1_o | output | 18 | First Gaussian sample, signed, 2^-11 units |
| x2_o | output | 18 | Second Gaussian sample, signed, 2^-11 units |

## Verification
Several properties are checked on every cycle by assertions:
- the spacing of `valid_o`;
- that a valid pair is never all-zero;
- that the outputs hold between pairs;
- that the buffer never over- or underflows;
- that a frozen source keeps its state and that no source reaches the zero state.

Three things only the bench's cycle-by-cycle reference can show:
- that each value is right, through the sequences, the radius rule, the rounded scale table and the products;
- that back-pressure freezes the sources at exactly the right moments, so that no accepted draw is lost or reordered;
- that a reset in mid-run restarts the identical sequence.

// File: rtl/gn_pkg.sv
package gn_pkg;
  localparam int U_W     = 4;
  localparam int N_SRC   = 2 * U_W;
  localparam int V_W     = U_W;
  localparam int S_W     = 2 * U_W;
  localparam int W_INT   = 6;
  localparam int W_FRAC  = 8;
  localparam int W_W     = W_INT + W_FRAC;
  localparam int X_W     = V_W + W_W;
  localparam int D_LIM   = 1 << (2 * (U_W - 1));
  localparam int S_SHIFT = S_W - 2 * (U_W - 1);

  typedef struct packed {
    logic signed [V_W-1:0] v1;
    logic signed [V_W-1:0] v2;
    logic [S_W-1:0]        s;
  } draw_t;

  function automatic int src_len(int i);
    case (i)
      0: return 5;   1: return 6;   2: return 7;   3: return 9;
      4: return 10;  5: return 11;  6: return 15;  default: return 17;
    endcase
  endfunction

  function automatic int src_tap(int i);
    case (i)
      0: return 3;   1: return 5;   2: return 6;   3: return 5;
      4: return 7;   5: return 9;   6: return 14;  default: return 14;
    endcase
  endfunction

  // radius code for address {u1,u2}; 0 marks a rejected draw
  function automatic logic [S_W-1:0] s_code(int a);
    int u1, u2, d1, d2, d;
    u1 = (a >> U_W) & ((1 << U_W) - 1);
    u2 = a & ((1 << U_W) - 1);
    d1 = u1 - (1 << (U_W - 1));
    d2 = u2 - (1 << (U_W - 1));
    d  = d1 * d1 + d2 * d2;
    if (d >= D_LIM) return '0;
    return S_W'(d << S_SHIFT);
  endfunction

  function automatic logic [W_W-1:0] w_code(int s);
    real x, w;
    int  c;
    if (s == 0) return '0;
    x = real'(s) / real'(1 << S_W);
    w = $sqrt(-2.0 * $ln(x) / x);
    c = int'(w * real'(1 << W_FRAC));
    if (c > (1 << W_W) - 1) c = (1 << W_W) - 1;
    return W_W'(c);
  endfunction
endpackage

// File: rtl/gn_lfsr.sv
module gn_lfsr #(
  parameter int LEN = 5,
  parameter int TAP = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic bit_o
);
  logic [LEN-1:0] state_q;
  logic           fb;

  assign fb    = state_q[LEN-1] ^ state_q[TAP-1];
  assign bit_o = state_q[LEN-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   state_q <= '1;
    else if (en_i) state_q <= {state_q[LEN-2:0], fb};
  end

  a_r2_never_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
  a_r4_frozen_when_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(state_q));
endmodule

// File: rtl/gn_uniform_src.sv
module gn_uniform_src
  import gn_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  output logic [U_W-1:0] u1_o,
  output logic [U_W-1:0] u2_o
);
  logic [N_SRC-1:0] bits;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    gn_lfsr #(.LEN(src_len(i)), .TAP(src_tap(i))) u_lfsr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (en_i),
      .bit_o (bits[i])
    );
  end

  assign u1_o = bits[U_W-1:0];
  assign u2_o = bits[N_SRC-1:U_W];
endmodule

// File: rtl/gn_fifo.sv
module gn_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign rdata_o = mem_q[rp_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_i) wp_q <= bump(wp_q);
      if (rd_i) rp_q <= bump(rp_q);
      if (wr_i && !rd_i)      cnt_q <= cnt_q + 1'b1;
      else if (rd_i && !wr_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[wp_q] <= wdata_i;
  end

  a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> !full_o);
  a_r4_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> !empty_o);
endmodule

// File: rtl/gn_scale.sv
module gn_scale
  import gn_pkg::*;
(
  input  draw_t                 draw_i,
  output logic signed [X_W-1:0] x1_o,
  output logic signed [X_W-1:0] x2_o
);
  localparam int N_ROM = 1 << S_W;

  logic [W_W-1:0] w_rom [N_ROM];
  logic [W_W-1:0] w;

  for (genvar i = 0; i < N_ROM; i++) begin : g_wrom
    localparam logic [W_W-1:0] ENTRY = w_code(i);
    assign w_rom[i] = ENTRY;
  end

  assign w    = w_rom[draw_i.s];
  assign x1_o = X_W'(draw_i.v1) * X_W'($signed({1'b0, w}));
  assign x2_o = X_W'(draw_i.v2) * X_W'($signed({1'b0, w}));
endmodule

// File: rtl/gn_polar_noise.sv
module gn_polar_noise
  import gn_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  output logic                         valid_o,
  output logic signed [gn_pkg::X_W-1:0] x1_o,
  output logic signed [gn_pkg::X_W-1:0] x2_o
);
  localparam int N_SROM = 1 << S_W;
  localparam int DW     = $bits(draw_t);

  logic [U_W-1:0]        u1, u2;
  logic [S_W-1:0]        s_rom [N_SROM];
  logic [S_W-1:0]        s;
  logic                  full, empty, adv, wr, rd;
  logic                  slot_q;
  draw_t                 wdraw, rdraw;
  logic signed [X_W-1:0] x1, x2;

  gn_uniform_src u_src (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (adv),
    .u1_o  (u1),
    .u2_o  (u2)
  );

  for (genvar i = 0; i < N_SROM; i++) begin : g_srom
    localparam logic [S_W-1:0] ENTRY = s_code(i);
    assign s_rom[i] = ENTRY;
  end

  assign s        = s_rom[{u1, u2}];
  assign adv      = !full;
  assign wr       = adv && (s != '0);
  assign wdraw.v1 = u1 - U_W'(1 << (U_W - 1));
  assign wdraw.v2 = u2 - U_W'(1 << (U_W - 1));
  assign wdraw.s  = s;
  assign rd       = slot_q && !empty;

  gn_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr),
    .wdata_i(wdraw),
    .rd_i   (rd),
    .rdata_o(rdraw),
    .full_o (full),
    .empty_o(empty)
  );

  gn_scale u_scale (
    .draw_i(rdraw),
    .x1_o  (x1),
    .x2_o  (x2)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q  <= 1'b0;
      valid_o <= 1'b0;
      x1_o    <= '0;
      x2_o    <= '0;
    end else begin
      slot_q  <= !slot_q;
      valid_o <= rd;
      if (rd) begin
        x1_o <= x1;
        x2_o <= x2;
      end
    end
  end

  a_r5_spaced_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  a_r9_no_rejected_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (x1_o != '0 || x2_o != '0));
  a_r7_hold_x1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(x1_o));
  a_r7_hold_x2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(x2_o));
endmodule

// File: tb/tb_gn_polar_noise.sv
`timescale 1ns/1ps
module tb_gn_polar_noise;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_o;
  logic signed [17:0] x1_o, x2_o;

  always #2.5 clk = ~clk;

  gn_polar_noise dut (.clk_i(clk), .rst_ni(rst_n), .valid_o(valid_o),
                      .x1_o(x1_o), .x2_o(x2_o));

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  // reference model state
  int lens[8] = '{5, 6, 7, 9, 10, 11, 15, 17};
  int taps[8] = '{3, 5, 6, 5, 7, 9, 14, 14};
  int st[8];
  int q[$];
  bit slot;
  bit exp_valid;
  int exp_x1, exp_x2;
  bit prev_valid;
  int run_idx = 0;
  bit got_first[2];
  int first_x1[2], first_x2[2];

  function automatic int w_ref(int s);
    real x, w;
    int c;
    if (s == 0) return 0;
    x = s / 256.0;
    w = $sqrt(-2.0 * $ln(x) / x);
    c = $rtoi(w * 256.0 + 0.5);
    if (c > 16383) c = 16383;
    return c;
  endfunction

  function automatic int src_bit(int v, int len);
    return (v >> (len - 1)) & 1;
  endfunction

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // cycle model: R2 sources, R3 radius and rejection, R4 stall, R5 slots, R6/R7 products
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) st[i] = (1 << lens[i]) - 1;
      q.delete();
      slot = 0;
      exp_valid = 0;
      exp_x1 = 0;
      exp_x2 = 0;
    end else begin
      int u1, u2, d, s, e, w;
      bit full, empty;
      u1 = 0; u2 = 0;
      for (int i = 0; i < 4; i++) begin
        u1 |= src_bit(st[i], lens[i]) << i;
        u2 |= src_bit(st[4+i], lens[4+i]) << i;
      end
      full  = (q.size() == 16);
      empty = (q.size() == 0);
      exp_valid = 0;
      if (slot && !empty) begin
        e = q.pop_front();
        w = w_ref(e & 255);
        exp_x1 = (((e >> 12) & 15) - 8) * w;
        exp_x2 = (((e >> 8) & 15) - 8) * w;
        exp_valid = 1;
      end
      if (!full) begin
        d = (u1 - 8) * (u1 - 8) + (u2 - 8) * (u2 - 8);
        s = (d > 0 && d < 64) ? d * 4 : 0;
        if (s != 0) q.push_back((u1 << 12) | (u2 << 8) | s);
        for (int i = 0; i < 8; i++) begin
          int fb;
          fb = src_bit(st[i], lens[i]) ^ ((st[i] >> (taps[i] - 1)) & 1);
          st[i] = ((st[i] << 1) | fb) & ((1 << lens[i]) - 1);
        end
      end
      slot = !slot;
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R5 valid_o", int'(valid_o), int'(exp_valid));
      check("R7/R8 x1_o", int'(x1_o), exp_x1);
      check("R7/R8 x2_o", int'(x2_o), exp_x2);
      if (valid_o) begin
        check("R9 nonzero pair", int'(x1_o != 0 || x2_o != 0), 1);
        check("R5 no back-to-back valid", int'(prev_valid), 0);
        if (!got_first[run_idx]) begin
          got_first[run_idx] = 1;
          first_x1[run_idx] = int'(x1_o);
          first_x2[run_idx] = int'(x2_o);
        end
      end
      prev_valid = valid_o;
    end else begin
      prev_valid = 0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected below 200000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(valid_o), 0);
    check("R1 x1 in reset", int'(x1_o), 0);
    #1 rst_n = 1'b1;
    repeat (3000) @(negedge clk);
    #1 rst_n = 1'b0;
    run_idx = 1;
    repeat (2) @(negedge clk);
    check("R1 valid after mid reset", int'(valid_o), 0);
    check("R1 x2 after mid reset", int'(x2_o), 0);
    #1 rst_n = 1'b1;
    repeat (1500) @(negedge clk);
    check("R1 first pair seen both runs", int'(got_first[0] && got_first[1]), 1);
    check("R1 restart x1 repeats", first_x1[1], first_x1[0]);
    check("R1 restart x2 repeats", first_x2[1], first_x2[0]);
    finish_run();
  end
endmodule